// File: doc/BRIEF.md
# Interrupt Pending Register with Build-Time Bit Ownership

This block holds the interrupt-pending vector of a processor hart that runs at machine and supervisor privilege. Every pending bit has exactly one owner. Either it mirrors a hardware interrupt line, or it is a plain storage bit that control-register writes may set and clear. The ownership split for the three supervisor bits is fixed when the block is built, through the parameter `OWN_CFG`. The three machine bits are always owned by hardware.

The control-register side is a write strobe with a data word and a per-bit write mask. A write changes only the bits that are both selected by the mask and owned by software. Writes to every other bit are dropped without any indication. There is no separate read strobe. `pend_vec` is the registered pending vector at all times, so a read returns the value that was latched at the most recent clock edge. All pins are plain control and status signals. There is no flow control on any of them.

`OWN_CFG` selects the ownership split:
- 1: machine bits only; all supervisor bits are absent.
- 2: all supervisor bits are software-writable.
- 3: supervisor external follows its line; supervisor timer and supervisor software are software-writable.
- 4: all supervisor bits follow their lines.

Top module: `irq_pend_reg`

## Requirements
- R1: The machine external, timer and software pending bits (positions 11, 7 and 3) take the value of `m_ext_irq`, `m_tmr_irq` and `m_sw_irq` at each clock edge. Writes never change them.
- R2: Bit positions are fixed as follows: supervisor software at 1, machine software at 3, supervisor timer at 5, machine timer at 7, supervisor external at 9, machine external at 11.
- R3: With `OWN_CFG`=1, bits 1, 5 and 9 always read 0. Neither writes nor the supervisor lines change them.
- R4: With `OWN_CFG`=2, bits 1, 5 and 9 are set and cleared only by writes. The supervisor lines have no effect on them.
- R5: With `OWN_CFG`=3, bit 9 follows `s_ext_irq` and ignores writes. Bits 5 and 1 are software-writable and ignore their lines.
- R6: With `OWN_CFG`=4, bits 9, 5 and 1 follow `s_ext_irq`, `s_tmr_irq` and `s_sw_irq`. Writes to them are discarded.
- R7: A write updates a software-owned bit to `csr_wdata` only where `csr_wmask` is 1. Software-owned bits hold their value when the mask bit is 0 or when `csr_we` is low.
- R8: Every bit position other than the six listed in R2 reads 0 in every configuration.
- R9: An active-low `rst_n` clears every bit of `pend_vec`.
- R10: `pend_vec` is registered. A change on a line or a write is visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_ext_irq | input | 1 | Machine external interrupt line |
| m_tmr_irq | input | 1 | Machine timer interrupt line |
| m_sw_irq | input | 1 | Machine software interrupt line |
| s_ext_irq | input | 1 | Supervisor external interrupt line (used when hardware-owned) |
| s_tmr_irq | input | 1 | Supervisor timer interrupt line (used when hardware-owned) |
| s_sw_irq | input | 1 | Supervisor software interrupt line (used when hardware-owned) |
| csr_we | input | 1 | Write strobe for the pending register |
| csr_wdata | input | PEND_W | Write data |
| csr_wmask | input | PEND_W | Per-bit write mask; 1 selects the bit |
| pend_vec | output | PEND_W | Registered pending vector, also the read data |

## Verification
The assertions assume that the interrupt lines, `csr_we`, `csr_wdata` and `csr_wmask` are synchronous to `clk` and stable around each rising edge. They also assume that `rst_n` is held low for at least one edge before it is released. The stimulus satisfies this by changing every input only on the falling edge. It also holds the lines steady across each edge that a check depends on. All four ownership configurations are built side by side and driven by the same inputs. This lets one write or one line change be compared across every ownership split.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int unsigned SSI_POS = 1;
  localparam int unsigned MSI_POS = 3;
  localparam int unsigned STI_POS = 5;
  localparam int unsigned MTI_POS = 7;
  localparam int unsigned SEI_POS = 9;
  localparam int unsigned MEI_POS = 11;
  localparam int unsigned MIN_W   = 12;

  typedef struct packed {
    logic ext;
    logic tmr;
    logic sw;
  } irq_trio_t;

  // Hardware ownership of the supervisor trio for a configuration.
  function automatic irq_trio_t sup_hw_own(input int unsigned cfg);
    irq_trio_t t;
    t = '0;
    if (cfg == 3) t.ext = 1'b1;
    if (cfg == 4) t = '1;
    return t;
  endfunction

  // Software ownership of the supervisor trio for a configuration.
  function automatic irq_trio_t sup_sw_own(input int unsigned cfg);
    irq_trio_t t;
    t = '0;
    if (cfg == 2) t = '1;
    if (cfg == 3) begin
      t.tmr = 1'b1;
      t.sw  = 1'b1;
    end
    return t;
  endfunction

endpackage

// File: rtl/irq_own_map.sv
module irq_own_map
  import irq_pend_pkg::*;
#(
  parameter int unsigned PEND_W  = 16,
  parameter int unsigned OWN_CFG = 3
) (
  output logic [PEND_W-1:0] hw_mask,
  output logic [PEND_W-1:0] sw_mask
);
  localparam irq_trio_t HW_S = sup_hw_own(OWN_CFG);
  localparam irq_trio_t SW_S = sup_sw_own(OWN_CFG);

  for (genvar i = 0; i < PEND_W; i++) begin : g_bit
    if (i == MEI_POS || i == MTI_POS || i == MSI_POS) begin : g_mach
      assign hw_mask[i] = 1'b1;
      assign sw_mask[i] = 1'b0;
    end else if (i == SEI_POS) begin : g_sei
      assign hw_mask[i] = HW_S.ext;
      assign sw_mask[i] = SW_S.ext;
    end else if (i == STI_POS) begin : g_sti
      assign hw_mask[i] = HW_S.tmr;
      assign sw_mask[i] = SW_S.tmr;
    end else if (i == SSI_POS) begin : g_ssi
      assign hw_mask[i] = HW_S.sw;
      assign sw_mask[i] = SW_S.sw;
    end else begin : g_none
      assign hw_mask[i] = 1'b0;
      assign sw_mask[i] = 1'b0;
    end
  end

  always_comb begin
    a_r5_single_owner: assert ((hw_mask & sw_mask) == '0);
  end
endmodule

// File: rtl/irq_hw_sample.sv
module irq_hw_sample
  import irq_pend_pkg::*;
#(
  parameter int unsigned PEND_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irq_trio_t         m_lines,
  input  irq_trio_t         s_lines,
  input  logic [PEND_W-1:0] hw_mask,
  output logic [PEND_W-1:0] hw_q
);
  logic [PEND_W-1:0] line_vec;

  always_comb begin
    line_vec          = '0;
    line_vec[MEI_POS] = m_lines.ext;
    line_vec[MTI_POS] = m_lines.tmr;
    line_vec[MSI_POS] = m_lines.sw;
    line_vec[SEI_POS] = s_lines.ext;
    line_vec[STI_POS] = s_lines.tmr;
    line_vec[SSI_POS] = s_lines.sw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_q <= '0;
    else        hw_q <= line_vec & hw_mask;
  end

  a_r10_hw_latency: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hw_q[MEI_POS] == $past(m_lines.ext)));
endmodule

// File: rtl/irq_sw_store.sv
module irq_sw_store #(
  parameter int unsigned PEND_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PEND_W-1:0] wdata,
  input  logic [PEND_W-1:0] wmask,
  input  logic [PEND_W-1:0] sw_mask,
  output logic [PEND_W-1:0] sw_q
);
  logic [PEND_W-1:0] sel;
  assign sel = wmask & sw_mask;

  for (genvar i = 0; i < PEND_W; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             sw_q[i] <= 1'b0;
      else if (we && sel[i])  sw_q[i] <= wdata[i];
    end
  end

  a_r7_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(sw_q));

  a_r7_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (((sw_q ^ $past(sw_q)) & ~$past(wmask)) == '0));

  a_r7_masked_take: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((sw_q & $past(sel)) == ($past(wdata) & $past(sel))));
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pend_pkg::*;
#(
  parameter int unsigned PEND_W  = 16,
  parameter int unsigned OWN_CFG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_ext_irq,
  input  logic              m_tmr_irq,
  input  logic              m_sw_irq,
  input  logic              s_ext_irq,
  input  logic              s_tmr_irq,
  input  logic              s_sw_irq,
  input  logic              csr_we,
  input  logic [PEND_W-1:0] csr_wdata,
  input  logic [PEND_W-1:0] csr_wmask,
  output logic [PEND_W-1:0] pend_vec
);
  localparam logic [PEND_W-1:0] SUP_POS =
    (PEND_W'(1) << SEI_POS) | (PEND_W'(1) << STI_POS) | (PEND_W'(1) << SSI_POS);
  localparam logic [PEND_W-1:0] MACH_POS =
    (PEND_W'(1) << MEI_POS) | (PEND_W'(1) << MTI_POS) | (PEND_W'(1) << MSI_POS);
  localparam logic [PEND_W-1:0] LEGAL = (OWN_CFG == 1) ? MACH_POS : (MACH_POS | SUP_POS);

  irq_trio_t         m_lines, s_lines;
  logic [PEND_W-1:0] hw_mask, sw_mask, hw_q, sw_q;

  assign m_lines = '{ext: m_ext_irq, tmr: m_tmr_irq, sw: m_sw_irq};
  assign s_lines = '{ext: s_ext_irq, tmr: s_tmr_irq, sw: s_sw_irq};

  irq_own_map #(.PEND_W(PEND_W), .OWN_CFG(OWN_CFG)) u_map (
    .hw_mask (hw_mask),
    .sw_mask (sw_mask)
  );

  irq_hw_sample #(.PEND_W(PEND_W)) u_hw (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_lines (m_lines),
    .s_lines (s_lines),
    .hw_mask (hw_mask),
    .hw_q    (hw_q)
  );

  irq_sw_store #(.PEND_W(PEND_W)) u_sw (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (csr_we),
    .wdata   (csr_wdata),
    .wmask   (csr_wmask),
    .sw_mask (sw_mask),
    .sw_q    (sw_q)
  );

  assign pend_vec = hw_q | sw_q;

  a_r1_mach_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_vec[MEI_POS] == $past(m_ext_irq)) &&
             (pend_vec[MTI_POS] == $past(m_tmr_irq)) &&
             (pend_vec[MSI_POS] == $past(m_sw_irq)));

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec & ~LEGAL) == '0);

  if (OWN_CFG == 3 || OWN_CFG == 4) begin : g_sei_hw
    a_r5_sei_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pend_vec[SEI_POS] == $past(s_ext_irq)));
  end
  if (OWN_CFG == 4) begin : g_all_hw
    a_r6_sup_follow: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pend_vec[STI_POS] == $past(s_tmr_irq)) &&
               (pend_vec[SSI_POS] == $past(s_sw_irq)));
  end
  if (OWN_CFG == 2) begin : g_all_sw
    a_r4_sup_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_we |=> $stable(pend_vec & SUP_POS));
  end
endmodule

// File: tb/irq_pend_reg_tb.sv
module irq_pend_reg_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_ext = 0, m_tmr = 0, m_sw = 0, s_ext = 0, s_tmr = 0, s_sw = 0;
  logic we = 0;
  logic [W-1:0] wdata = '0, wmask = '0;
  logic [W-1:0] pv [1:4];
  logic [W-1:0] sw_model [1:4];
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_pend_reg #(.PEND_W(W), .OWN_CFG(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .m_ext_irq(m_ext), .m_tmr_irq(m_tmr), .m_sw_irq(m_sw),
    .s_ext_irq(s_ext), .s_tmr_irq(s_tmr), .s_sw_irq(s_sw), .csr_we(we),
    .csr_wdata(wdata), .csr_wmask(wmask), .pend_vec(pv[3]));
  irq_pend_reg #(.PEND_W(W), .OWN_CFG(1)) u_cfg1 (
    .clk(clk), .rst_n(rst_n), .m_ext_irq(m_ext), .m_tmr_irq(m_tmr), .m_sw_irq(m_sw),
    .s_ext_irq(s_ext), .s_tmr_irq(s_tmr), .s_sw_irq(s_sw), .csr_we(we),
    .csr_wdata(wdata), .csr_wmask(wmask), .pend_vec(pv[1]));
  irq_pend_reg #(.PEND_W(W), .OWN_CFG(2)) u_cfg2 (
    .clk(clk), .rst_n(rst_n), .m_ext_irq(m_ext), .m_tmr_irq(m_tmr), .m_sw_irq(m_sw),
    .s_ext_irq(s_ext), .s_tmr_irq(s_tmr), .s_sw_irq(s_sw), .csr_we(we),
    .csr_wdata(wdata), .csr_wmask(wmask), .pend_vec(pv[2]));
  irq_pend_reg #(.PEND_W(W), .OWN_CFG(4)) u_cfg4 (
    .clk(clk), .rst_n(rst_n), .m_ext_irq(m_ext), .m_tmr_irq(m_tmr), .m_sw_irq(m_sw),
    .s_ext_irq(s_ext), .s_tmr_irq(s_tmr), .s_sw_irq(s_sw), .csr_we(we),
    .csr_wdata(wdata), .csr_wmask(wmask), .pend_vec(pv[4]));

  // Ownership per configuration, from R3-R6 (positions from R2).
  function automatic logic [W-1:0] sw_set(input int c);
    case (c)
      2: return 16'h0222;
      3: return 16'h0022;
      default: return 16'h0000;
    endcase
  endfunction
  function automatic logic [W-1:0] hw_sup(input int c);
    case (c)
      3: return 16'h0200;
      4: return 16'h0222;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [W-1:0] expect_of(input int c);
    logic [W-1:0] lines;
    lines = '0;
    lines[11] = m_ext; lines[7] = m_tmr; lines[3] = m_sw;
    lines[9] = s_ext;  lines[5] = s_tmr; lines[1] = s_sw;
    return (lines & 16'h0888) | (lines & hw_sup(c)) | sw_model[c];
  endfunction

  task automatic check(input string req, input int c, input logic [W-1:0] exp);
    n_chk++;
    if (pv[c] !== exp) begin
      n_fail++;
      $display("FAIL %s cfg%0d: actual %h expected %h", req, c, pv[c], exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 1; c <= 4; c++) check(req, c, expect_of(c));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_lines(input logic me, mt, ms, se, st, ss);
    m_ext = me; m_tmr = mt; m_sw = ms; s_ext = se; s_tmr = st; s_sw = ss;
  endtask

  task automatic do_write(input logic [W-1:0] d, input logic [W-1:0] m);
    we = 1'b1; wdata = d; wmask = m;
    step();
    we = 1'b0;
    for (int c = 1; c <= 4; c++)
      sw_model[c] = (sw_model[c] & ~(m & sw_set(c))) | (d & m & sw_set(c));
  endtask

  task automatic t_reset();
    for (int c = 1; c <= 4; c++) check("R9 reset", c, '0);
  endtask

  task automatic t_machine();
    set_lines(1, 1, 1, 0, 0, 0);
    step();
    check_all("R1/R2 machine lines high");
    do_write(16'h0000, 16'hFFFF);
    check_all("R1 write cannot clear machine bits");
    set_lines(0, 0, 0, 0, 0, 0);
    do_write(16'hFFFF, 16'hFFFF);
    check_all("R1/R3/R8 write all ones");
  endtask

  task automatic t_sup_lines();
    set_lines(0, 0, 0, 1, 1, 1);
    step();
    check_all("R4/R5/R6 supervisor lines high");
    do_write(16'h0000, 16'hFFFF);
    check_all("R5/R6 write discarded on hw bits");
    set_lines(0, 0, 0, 0, 0, 0);
    step();
    check_all("R3/R6 supervisor lines low");
  endtask

  task automatic t_mask();
    do_write(16'hFFFF, 16'hFFFF);
    do_write(16'h0000, 16'h0020);
    check("R7 masked clear", 2, 16'h0202);
    check_all("R7 masked clear all cfgs");
    we = 1'b0; wdata = 16'h0000; wmask = 16'hFFFF;
    step();
    check_all("R7 no strobe holds");
    do_write(16'h0020, 16'h0000);
    check("R7 zero mask holds", 2, 16'h0202);
  endtask

  task automatic t_latency();
    m_ext = 1'b1;
    #2;
    check("R10 before edge", 3, 16'h0000 | sw_model[3]);
    step();
    check("R10 after edge", 3, 16'h0800 | sw_model[3]);
    m_ext = 1'b0;
    step();
  endtask

  task automatic t_mid_reset();
    set_lines(1, 0, 1, 1, 0, 1);
    do_write(16'hFFFF, 16'hFFFF);
    rst_n = 1'b0;
    #2;
    for (int c = 1; c <= 4; c++) begin
      sw_model[c] = '0;
      check("R9 mid-run reset", c, '0);
    end
    step();
    set_lines(0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    step();
    check_all("R9 after release");
  endtask

  initial begin
    for (int c = 1; c <= 4; c++) sw_model[c] = '0;
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_machine();
    t_sup_lines();
    t_mask();
    t_latency();
    t_mid_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule